// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

A single copy channel that moves data between two descriptor rings kept in a built-in word memory. A host programs a source ring and a destination ring, each set by a base word address, an entry count and a write index. It places source descriptors that point at filled buffers and destination descriptors that point at empty receive buffers, then advances the write indices. The engine walks the pending source descriptors in order and copies each buffer into the next posted receive buffer. It writes the byte count and flags back into the destination descriptor and raises a copy-complete interrupt.

A run of source descriptors flagged for gathering is merged into a single receive buffer and produces one completion. Each source descriptor is cut to a programmable maximum length. Byte order inside each 32-bit word can be reversed per descriptor. The host reaches the memory model through its own port, and that port takes priority over the engine.

Top module: `desc_copy_engine`

## Requirements
- R1: A descriptor takes two memory words at ring base + 2*index. The first word is a byte address whose bits [AW+1:2] select the buffer word. The second word holds the byte count in [15:0] and the flags in [31:16]. In the flags, bit 0 is gather, bit 1 is byte swap and bits [15:8] are metadata.
- R2: Ring indices wrap by masking with entry count minus one, and the engine's read indices can be read at register 3 (source) and register 7 (destination). The writable registers are source base 0, source size 1, source write index 2, destination base 4, destination size 5 and destination write index 6.
- R3: Source descriptors from the source read index up to the source write index are processed in ring order. Each copies ceil(count/4) words, and the source read index advances by one per descriptor.
- R4: A run of gather-flagged source descriptors, ended by one without the flag, fills one destination buffer back to back and produces exactly one completion.
- R5: On completion the destination descriptor's second word becomes {last source flags with bit 0 cleared, summed byte count}, and the destination read index advances by one.
- R6: Write index equal to read index means empty, so a ring of N entries carries up to N-1 posted descriptors, and all of them are processed.
- R7: Status register 10 has bit 0 for copy complete and bit 1 for truncation error, and it is cleared by writing ones. A new event in the same cycle as a clear leaves the bit set. Enable register 9 gates irq_o = |(status & enable).
- R8: A source byte count above the maximum in register 8 [15:0] is cut to that maximum, and status bit 1 is set.
- R9: With source data pending and no destination buffer posted, the engine waits without consuming the source descriptor until the destination write index advances.
- R10: With the byte-swap flag set, each copied word has its four bytes reversed, and the flag is carried into the destination descriptor.
- R11: A size register of zero disables its ring. Its write index is then ignored and no transfer starts.
- R12: Watermark registers 11 (source) and 12 (destination) store 32 bits and read back. Writing zero to base, size, maximum length and watermark clears a ring's settings.
- R13: A host memory write always lands. The engine pauses for that cycle and still finishes its transfer intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| mem_we_i | input | 1 | Host memory write strobe |
| mem_addr_i | input | AW | Host memory word address |
| mem_wdata_i | input | 32 | Host memory write data |
| mem_rdata_o | output | 32 | Host memory read data, combinational |
| irq_o | output | 1 | Copy-complete or error interrupt |

## Verification
Two events can fall in the same cycle: the write-back that sets the copy-complete status bit, and a host write-one-to-clear of that same bit. The race is provoked by starting a one-word transfer from an idle engine and timing the clear to land on the seventh edge after the source write index is taken. That edge is the one at which the write-back commits. The test is judged by reading the status back as set and irq_o as high, and then showing that a plain clear afterwards does drop the bit. A second overlap, host memory writes during an active copy, is judged by the copied data and the host word both being intact.

// File: rtl/ce_pkg.sv
package ce_pkg;
  localparam logic [3:0] RA_SRC_BASE = 4'd0;
  localparam logic [3:0] RA_SRC_SIZE = 4'd1;
  localparam logic [3:0] RA_SRC_WR   = 4'd2;
  localparam logic [3:0] RA_SRC_RD   = 4'd3;
  localparam logic [3:0] RA_DST_BASE = 4'd4;
  localparam logic [3:0] RA_DST_SIZE = 4'd5;
  localparam logic [3:0] RA_DST_WR   = 4'd6;
  localparam logic [3:0] RA_DST_RD   = 4'd7;
  localparam logic [3:0] RA_DMA_MAX  = 4'd8;
  localparam logic [3:0] RA_INT_EN   = 4'd9;
  localparam logic [3:0] RA_INT_STAT = 4'd10;
  localparam logic [3:0] RA_SRC_WM   = 4'd11;
  localparam logic [3:0] RA_DST_WM   = 4'd12;

  localparam int FL_GATHER = 0;
  localparam int FL_SWAP   = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_SD0, S_SD1, S_DD0, S_COPY, S_SDONE, S_DWB
  } eng_state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/ce_mem.sv
module ce_mem #(
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [31:0]   host_wdata_i,
  output logic [31:0]   host_rdata_o,
  input  logic [AW-1:0] eng_raddr_i,
  output logic [31:0]   eng_rdata_o,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_waddr_i,
  input  logic [31:0]   eng_wdata_i
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (host_we_i)     mem_q[host_addr_i] <= host_wdata_i;
    else if (eng_we_i) mem_q[eng_waddr_i] <= eng_wdata_i;
  end

  assign host_rdata_o = mem_q[host_addr_i];
  assign eng_rdata_o  = mem_q[eng_raddr_i];

  p_host_wins_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> mem_q[$past(host_addr_i)] == $past(host_wdata_i));
endmodule

// File: rtl/ce_regs.sv
module ce_regs import ce_pkg::*; #(
  parameter int AW = 8,
  parameter int IW = 4,
  localparam int SW = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [IW-1:0] src_rd_i,
  input  logic [IW-1:0] dst_rd_i,
  input  logic          done_i,
  input  logic          err_i,
  output logic [AW-1:0] src_base_o,
  output logic [SW-1:0] src_size_o,
  output logic [IW-1:0] src_wr_o,
  output logic [AW-1:0] dst_base_o,
  output logic [SW-1:0] dst_size_o,
  output logic [IW-1:0] dst_wr_o,
  output logic [15:0]   dma_max_o,
  output logic          src_clr_o,
  output logic          dst_clr_o,
  output logic          irq_o
);
  logic [1:0]  en_q, stat_q, w1c;
  logic [31:0] src_wm_q, dst_wm_q;

  assign w1c       = (we_i && addr_i == RA_INT_STAT) ? wdata_i[1:0] : 2'b00;
  assign src_clr_o = we_i && addr_i == RA_SRC_SIZE;
  assign dst_clr_o = we_i && addr_i == RA_DST_SIZE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_base_o <= '0; src_size_o <= '0; src_wr_o <= '0;
      dst_base_o <= '0; dst_size_o <= '0; dst_wr_o <= '0;
      dma_max_o  <= '0; en_q <= '0; stat_q <= '0;
      src_wm_q   <= '0; dst_wm_q <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          RA_SRC_BASE: src_base_o <= wdata_i[AW-1:0];
          RA_SRC_SIZE: src_size_o <= wdata_i[SW-1:0];
          RA_SRC_WR:   src_wr_o   <= wdata_i[IW-1:0];
          RA_DST_BASE: dst_base_o <= wdata_i[AW-1:0];
          RA_DST_SIZE: dst_size_o <= wdata_i[SW-1:0];
          RA_DST_WR:   dst_wr_o   <= wdata_i[IW-1:0];
          RA_DMA_MAX:  dma_max_o  <= wdata_i[15:0];
          RA_INT_EN:   en_q       <= wdata_i[1:0];
          RA_SRC_WM:   src_wm_q   <= wdata_i;
          RA_DST_WM:   dst_wm_q   <= wdata_i;
          default: ;
        endcase
      end
      // a new event wins over a same-cycle clear
      stat_q <= (stat_q & ~w1c) | {err_i, done_i};
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_SRC_BASE: rdata_o = 32'(src_base_o);
      RA_SRC_SIZE: rdata_o = 32'(src_size_o);
      RA_SRC_WR:   rdata_o = 32'(src_wr_o);
      RA_SRC_RD:   rdata_o = 32'(src_rd_i);
      RA_DST_BASE: rdata_o = 32'(dst_base_o);
      RA_DST_SIZE: rdata_o = 32'(dst_size_o);
      RA_DST_WR:   rdata_o = 32'(dst_wr_o);
      RA_DST_RD:   rdata_o = 32'(dst_rd_i);
      RA_DMA_MAX:  rdata_o = 32'(dma_max_o);
      RA_INT_EN:   rdata_o = 32'(en_q);
      RA_INT_STAT: rdata_o = 32'(stat_q);
      RA_SRC_WM:   rdata_o = src_wm_q;
      RA_DST_WM:   rdata_o = dst_wm_q;
      default:     rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat_q & en_q);

  p_status_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_q[0]);
  p_status_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[0] && !(we_i && addr_i == RA_INT_STAT && wdata_i[0])) |=> stat_q[0]);
  p_status_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RA_INT_STAT && wdata_i[0] && !done_i) |=> !stat_q[0]);
endmodule

// File: rtl/ce_engine.sv
module ce_engine import ce_pkg::*; #(
  parameter int AW = 8,
  parameter int IW = 4,
  localparam int SW = IW + 1,
  localparam int WW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [SW-1:0] src_size_i,
  input  logic [IW-1:0] src_wr_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [SW-1:0] dst_size_i,
  input  logic [IW-1:0] dst_wr_i,
  input  logic [15:0]   dma_max_i,
  input  logic          src_clr_i,
  input  logic          dst_clr_i,
  output logic [IW-1:0] src_rd_o,
  output logic [IW-1:0] dst_rd_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [31:0]   rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o
);
  eng_state_e st;
  logic [IW-1:0] src_rd, dst_rd, smask, dmask;
  logic [SW-1:0] s_m1, d_m1;
  logic [AW-1:0] s_ptr, d_ptr, sd_addr, dd_addr;
  logic [WW-1:0] words, wcnt;
  logic [15:0]   flags_q, total_q, len_t, total_n;
  logic          in_run, trunc, src_pend, dst_free;

  assign s_m1  = src_size_i - SW'(1);
  assign d_m1  = dst_size_i - SW'(1);
  assign smask = s_m1[IW-1:0];
  assign dmask = d_m1[IW-1:0];

  assign src_pend = (src_size_i != '0) && ((src_wr_i & smask) != src_rd);
  assign dst_free = (dst_size_i != '0) && ((dst_wr_i & dmask) != dst_rd);

  assign sd_addr = src_base_i + AW'({src_rd, 1'b0});
  assign dd_addr = dst_base_i + AW'({dst_rd, 1'b0});

  assign trunc   = rd_data_i[15:0] > dma_max_i;
  assign len_t   = trunc ? dma_max_i : rd_data_i[15:0];
  assign wcnt    = WW'((17'(len_t) + 17'd3) >> 2);
  assign total_n = in_run ? total_q + len_t : len_t;

  always_comb begin
    rd_addr_o = s_ptr;
    wr_en_o   = 1'b0;
    wr_addr_o = d_ptr;
    wr_data_o = flags_q[FL_SWAP] ? bswap32(rd_data_i) : rd_data_i;
    unique case (st)
      S_SD0:  rd_addr_o = sd_addr;
      S_SD1:  rd_addr_o = sd_addr + AW'(1);
      S_DD0:  rd_addr_o = dd_addr;
      S_COPY: wr_en_o   = !hold_i;
      S_DWB: begin
        wr_en_o   = !hold_i;
        wr_addr_o = dd_addr + AW'(1);
        wr_data_o = {flags_q & ~16'(1 << FL_GATHER), total_q};
      end
      default: ;
    endcase
  end

  assign done_o = (st == S_DWB) && !hold_i;
  assign err_o  = (st == S_SD1) && trunc && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; src_rd <= '0; dst_rd <= '0; in_run <= 1'b0;
      s_ptr <= '0; d_ptr <= '0; words <= '0; flags_q <= '0; total_q <= '0;
    end else begin
      if (!hold_i) begin
        unique case (st)
          S_IDLE: if (src_pend && dst_free) st <= S_SD0;
          S_SD0: begin
            s_ptr <= rd_data_i[AW+1:2];
            st    <= S_SD1;
          end
          S_SD1: begin
            flags_q <= rd_data_i[31:16];
            total_q <= total_n;
            words   <= wcnt;
            if (!in_run)        st <= S_DD0;
            else if (wcnt != 0) st <= S_COPY;
            else                st <= S_SDONE;
          end
          S_DD0: begin
            d_ptr <= rd_data_i[AW+1:2];
            st    <= (words != 0) ? S_COPY : S_SDONE;
          end
          S_COPY: begin
            s_ptr <= s_ptr + AW'(1);
            d_ptr <= d_ptr + AW'(1);
            words <= words - WW'(1);
            if (words == WW'(1)) st <= S_SDONE;
          end
          S_SDONE: begin
            src_rd <= (src_rd + IW'(1)) & smask;
            in_run <= flags_q[FL_GATHER];
            st     <= flags_q[FL_GATHER] ? S_IDLE : S_DWB;
          end
          S_DWB: begin
            dst_rd <= (dst_rd + IW'(1)) & dmask;
            in_run <= 1'b0;
            st     <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
      if (src_clr_i) src_rd <= '0;
      if (dst_clr_i) dst_rd <= '0;
    end
  end

  assign src_rd_o = src_rd;
  assign dst_rd_o = dst_rd;

  p_src_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_SD0) |-> ((src_wr_i & smask) != src_rd));
  p_dst_posted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_DD0) |-> ((dst_wr_i & dmask) != dst_rd));
  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_size_i != '0) |-> ((src_rd & ~smask) == '0));
  p_disabled_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_IDLE && src_size_i == '0 && !in_run) |=> (st == S_IDLE));
endmodule

// File: rtl/desc_copy_engine.sv
module desc_copy_engine #(
  parameter int AW = 8,
  parameter int RING_MAX = 16,
  localparam int IW = $clog2(RING_MAX),
  localparam int SW = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [31:0]   mem_wdata_i,
  output logic [31:0]   mem_rdata_o,
  output logic          irq_o
);
  logic [AW-1:0] src_base, dst_base, e_raddr, e_waddr;
  logic [SW-1:0] src_size, dst_size;
  logic [IW-1:0] src_wr, dst_wr, src_rd, dst_rd;
  logic [15:0]   dma_max;
  logic          src_clr, dst_clr, done, err, e_we;
  logic [31:0]   e_rdata, e_wdata;

  ce_regs #(.AW(AW), .IW(IW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .src_rd_i(src_rd), .dst_rd_i(dst_rd), .done_i(done), .err_i(err),
    .src_base_o(src_base), .src_size_o(src_size), .src_wr_o(src_wr),
    .dst_base_o(dst_base), .dst_size_o(dst_size), .dst_wr_o(dst_wr),
    .dma_max_o(dma_max), .src_clr_o(src_clr), .dst_clr_o(dst_clr), .irq_o(irq_o)
  );

  ce_engine #(.AW(AW), .IW(IW)) u_eng (
    .clk_i, .rst_ni, .hold_i(mem_we_i),
    .src_base_i(src_base), .src_size_i(src_size), .src_wr_i(src_wr),
    .dst_base_i(dst_base), .dst_size_i(dst_size), .dst_wr_i(dst_wr),
    .dma_max_i(dma_max), .src_clr_i(src_clr), .dst_clr_i(dst_clr),
    .src_rd_o(src_rd), .dst_rd_o(dst_rd), .done_o(done), .err_o(err),
    .rd_addr_o(e_raddr), .rd_data_i(e_rdata),
    .wr_en_o(e_we), .wr_addr_o(e_waddr), .wr_data_o(e_wdata)
  );

  ce_mem #(.AW(AW)) u_mem (
    .clk_i, .rst_ni,
    .host_we_i(mem_we_i), .host_addr_i(mem_addr_i),
    .host_wdata_i(mem_wdata_i), .host_rdata_o(mem_rdata_o),
    .eng_raddr_i(e_raddr), .eng_rdata_o(e_rdata),
    .eng_we_i(e_we), .eng_waddr_i(e_waddr), .eng_wdata_i(e_wdata)
  );
endmodule

// File: tb/tb_desc_copy_engine.sv
`timescale 1ns/1ps
module tb_desc_copy_engine;
  localparam int AW = 8;
  localparam int SB = 0, DB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, mem_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_wdata = '0, mem_rdata;
  logic [AW-1:0] mem_addr = '0;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  desc_copy_engine #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_we_i(mem_we), .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata), .mem_rdata_o(mem_rdata),
    .irq_o(irq)
  );

  // {byte count, flags, data seed}
  localparam logic [47:0] VEC [4] = '{
    48'h0008_1200_0100, 48'h0004_3402_0200, 48'h0006_5600_0300, 48'h0010_7802_0400};

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic mem_wr(input int a, input logic [31:0] d);
    @(negedge clk); mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = d;
    @(negedge clk); mem_we = 1'b0;
  endtask

  task automatic mem_rd(input int a, output logic [31:0] v);
    @(negedge clk); mem_addr = AW'(a); #1 v = mem_rdata;
  endtask

  task automatic put_src(input int slot, input int buf_w, input int nb, input logic [15:0] fl);
    mem_wr(SB + 2*slot, 32'(buf_w*4));
    mem_wr(SB + 2*slot + 1, {fl, 16'(nb)});
  endtask

  task automatic put_dst(input int slot, input int buf_w);
    mem_wr(DB + 2*slot, 32'(buf_w*4));
    mem_wr(DB + 2*slot + 1, 32'h0);
  endtask

  task automatic fill(input int buf_w, input int n, input logic [15:0] seed);
    for (int k = 0; k < n; k++) mem_wr(buf_w + k, {seed, 16'(k)});
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    for (int t = 0; t < 500; t++) begin
      reg_rd(4'd10, v);
      if (v[0]) return;
    end
    chk(req, 32'hFFFF_FFFF, 32'h1);
  endtask

  task automatic wait_idx(input logic [3:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    for (int t = 0; t < 500; t++) begin
      reg_rd(a, v);
      if (v == e) return;
    end
    chk(req, v, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_rd(4'd3, v);  chk("R2 reset src rd", v, 0);
    reg_rd(4'd10, v); chk("R7 reset status", v, 0);
    chk("R7 reset irq", 32'(irq), 0);

    reg_wr(4'd0, SB); reg_wr(4'd1, 4);
    reg_wr(4'd4, DB); reg_wr(4'd5, 4);
    reg_wr(4'd8, 64); reg_wr(4'd9, 1);

    // R12 watermark storage
    reg_wr(4'd11, 32'h0003_0001); reg_rd(4'd11, v); chk("R12 src wmark", v, 32'h0003_0001);
    reg_wr(4'd12, 32'h0005_0002); reg_rd(4'd12, v); chk("R12 dst wmark", v, 32'h0005_0002);

    // vector table: single transfers across all slots, wrapping
    for (int i = 0; i < 4; i++) begin
      logic [15:0] nb, fl, sd;
      int nw;
      {nb, fl, sd} = VEC[i];
      nw = (int'(nb) + 3) / 4;
      fill(64 + 8*i, nw, sd);
      put_dst(i, 128 + 8*i);
      put_src(i, 64 + 8*i, nb, fl);
      reg_wr(4'd6, (i + 1) & 3);
      reg_wr(4'd2, (i + 1) & 3);
      wait_done("R3 completion");
      chk("R7 irq raised", 32'(irq), 1);
      mem_rd(DB + 2*i + 1, v); chk("R5 R1 writeback", v, {fl & 16'hFFFE, nb});
      for (int k = 0; k < nw; k++) begin
        mem_rd(128 + 8*i + k, v);
        chk(fl[1] ? "R10 swapped data" : "R3 copied data", v,
            fl[1] ? bsw({sd, 16'(k)}) : {sd, 16'(k)});
      end
      reg_rd(4'd3, v); chk("R2 src rd wrap", v, (i + 1) & 3);
      reg_rd(4'd7, v); chk("R5 dst rd advance", v, (i + 1) & 3);
      reg_wr(4'd10, 1);
      reg_rd(4'd10, v); chk("R7 w1c", v, 0);
    end

    // R4 gather: 8 + 4 bytes into one buffer
    fill(200, 2, 16'h0A0A); fill(210, 1, 16'h0B0B);
    put_src(0, 200, 8, 16'h0901);
    put_src(1, 210, 4, 16'h0A00);
    put_dst(0, 220);
    reg_wr(4'd6, 1); reg_wr(4'd2, 2);
    wait_done("R4 completion");
    wait_idx(4'd3, 2, "R4 src rd");
    reg_rd(4'd7, v); chk("R4 single completion", v, 1);
    mem_rd(DB + 1, v); chk("R4 R5 gather writeback", v, {16'h0A00, 16'd12});
    mem_rd(220, v); chk("R4 data0", v, {16'h0A0A, 16'd0});
    mem_rd(221, v); chk("R4 data1", v, {16'h0A0A, 16'd1});
    mem_rd(222, v); chk("R4 data2", v, {16'h0B0B, 16'd0});
    reg_wr(4'd10, 3);

    // R8 truncation to 8 bytes
    reg_wr(4'd8, 8);
    mem_wr(232, 32'hDEAD_BEEF);
    put_src(2, 64, 16, 16'h0000);
    put_dst(1, 230);
    reg_wr(4'd6, 2); reg_wr(4'd2, 3);
    wait_done("R8 completion");
    reg_rd(4'd10, v); chk("R8 error bit", v, 3);
    mem_rd(DB + 3, v); chk("R8 count cut", v, {16'h0000, 16'd8});
    mem_rd(232, v); chk("R8 beyond limit untouched", v, 32'hDEAD_BEEF);
    reg_wr(4'd10, 3); reg_wr(4'd8, 64);

    // R9 stall with no receive buffer
    put_src(3, 210, 4, 16'h0000);
    reg_wr(4'd2, 0);
    repeat (40) @(negedge clk);
    reg_rd(4'd3, v);  chk("R9 src not consumed", v, 3);
    reg_rd(4'd10, v); chk("R9 no completion", v, 0);
    put_dst(2, 240);
    reg_wr(4'd6, 3);
    wait_done("R9 resume");
    mem_rd(240, v); chk("R9 data after resume", v, {16'h0B0B, 16'd0});
    reg_rd(4'd3, v); chk("R9 src rd", v, 0);
    reg_wr(4'd10, 3);

    // R7 race: clear lands on the write-back edge (7th edge after src wr)
    put_src(0, 210, 4, 16'h0000);
    put_dst(3, 241);
    reg_wr(4'd6, 0);
    reg_wr(4'd2, 1);
    repeat (5) @(negedge clk);
    reg_wr(4'd10, 1);
    reg_rd(4'd10, v); chk("R7 set wins over clear", v, 1);
    chk("R7 irq after race", 32'(irq), 1);
    reg_wr(4'd10, 1);
    reg_rd(4'd10, v); chk("R7 plain clear", v, 0);
    chk("R7 irq dropped", 32'(irq), 0);

    // R6 full ring (3 of 4) with R13 host writes during the copies
    for (int j = 0; j < 3; j++) begin
      fill(100 + 10*j, 2, 16'h0700 + 16'(j));
      put_src(j + 1, 100 + 10*j, 8, 16'h0000);
      put_dst(j, 160 + 10*j);
    end
    reg_wr(4'd6, 3); reg_wr(4'd2, 0);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); mem_we = 1'b1; mem_addr = AW'(250); mem_wdata = 32'(c + 32'h50);
    end
    @(negedge clk); mem_we = 1'b0;
    wait_idx(4'd7, 3, "R6 dst rd");
    reg_rd(4'd3, v); chk("R6 src rd", v, 0);
    mem_rd(250, v); chk("R13 host write kept", v, 32'h59);
    for (int j = 0; j < 3; j++)
      for (int k = 0; k < 2; k++) begin
        mem_rd(160 + 10*j + k, v);
        chk("R13 R6 data", v, {16'h0700 + 16'(j), 16'(k)});
      end
    reg_wr(4'd10, 3);

    // R11 disabled source ring
    reg_wr(4'd1, 0);
    reg_wr(4'd2, 1);
    put_dst(3, 245);
    reg_wr(4'd6, 0);
    repeat (40) @(negedge clk);
    reg_rd(4'd7, v);  chk("R11 no transfer", v, 3);
    reg_rd(4'd10, v); chk("R11 no status", v, 0);
    reg_rd(4'd3, v);  chk("R11 src rd", v, 0);

    // R12 clearing
    reg_wr(4'd2, 0); reg_wr(4'd0, 0); reg_wr(4'd8, 0); reg_wr(4'd11, 0);
    reg_rd(4'd0, v);  chk("R12 base cleared", v, 0);
    reg_rd(4'd1, v);  chk("R12 size cleared", v, 0);
    reg_rd(4'd8, v);  chk("R12 dma max cleared", v, 0);
    reg_rd(4'd11, v); chk("R12 wmark cleared", v, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule